// File: doc/BRIEF.md
# Triple-Oversampled Serial Bit Recovery

This block takes a serial line that has already been sampled three times per bit period by a bank of phase-shifted samplers. It turns those samples back into data bits. Every valid cycle delivers one group of three samples, earliest first. The block holds each group for one cycle in a staging register. While a group is held, the block looks for level changes between neighbouring samples and counts them by their position inside the group. At the end of every window of valid groups, the position with the most level changes becomes the bit edge. The sample one step after that edge is the one farthest from both neighbouring edges, so it is taken as the bit.

The choice of sample is made feed-forward: nothing is fed back to the samplers. When the transmitter and receiver clocks differ, the chosen sample walks across the group and wraps around. When it wraps from the last sample to the first, one group yields no bit. When it wraps from the first sample to the last, one group yields two bits. The output therefore carries a count of 0, 1 or 2 bits per cycle, together with a valid flag. A downstream gearbox absorbs the varying rate.

Top module: `os_data_recover`

## Requirements
- R1: While reset is asserted, the outputs read zero bits, count 0 and valid low. After reset, the assumed edge position is 0, the selected sample is index 1, and the remembered previous sample is 0.
- R2: Sample `smp_i[0]` is the earliest in a group. Edge position 0 means a level change between the last sample of the previous valid group and `smp_i[0]`. Position p (1 or 2) means a change between samples p-1 and p.
- R3: Level changes are counted per position over a window of WINDOW valid groups, including the group that closes the window. The position with the largest count becomes the edge position. A tie goes to the lowest position.
- R4: The selected sample index is (edge position + 1) mod 3. A new edge position applies from the first valid group after the group that closed the window.
- R5: A window that contains no level change leaves the edge position and the selection as they were.
- R6: If the selection used for the previous valid group was index 0 and the current selection is index 2, the current group yields two bits: `bits_o[0]` is sample 0 and `bits_o[1]` is sample 2. The count is 2.
- R7: If the selection used for the previous valid group was index 2 and the current selection is index 0, the current group yields no bit: count 0, valid low.
- R8: A group presented at a rising edge produces its result at the outputs after the following rising edge, two edges in total from the input.
- R9: A cycle with `smp_vld_i` low produces count 0 on the output two edges later. It does not advance the window, the counts or the remembered previous sample.
- R10: `bits_vld_o` is high exactly when `bit_cnt_o` is nonzero. Bit positions beyond the count read 0, so a single bit always appears in `bits_o[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| smp_vld_i | input | 1 | Qualifies `smp_i` this cycle |
| smp_i | input | OVS (3) | One group of raw samples, bit 0 earliest |
| bits_o | output | 2 | Recovered bits, bit 0 first in time |
| bit_cnt_o | output | 2 | Number of valid bits in `bits_o` (0, 1 or 2) |
| bits_vld_o | output | 1 | At least one recovered bit this cycle |

## Verification
The hardest states to reach from the ports are the two wrap slips. Each one needs the window decision to move the selection across the end of the group, and that takes a whole window of consistent edge positions. The stimulus table builds that history on purpose. It sends windows of alternating bits aligned to edge position 0, then 2, then 1, then back to 2. The selection therefore walks 1, 0, 2, 0, and both the two-bit group and the empty group appear. The table also places idle cycles in the middle of a window. It then sends an edgeless window and a tied window. Each is followed by a group whose samples differ in every position, so the selection that actually took effect shows up in the output bit.

// File: rtl/os_rx_pkg.sv
package os_rx_pkg;

   // Position of a sample inside one oversampled group.
   typedef logic [1:0] phase_t;

   // Advance a position by one, wrapping at the group size.
   function automatic phase_t next_phase(phase_t p, int n);
      return (int'(p) == n - 1) ? phase_t'(0) : phase_t'(p + 2'd1);
   endfunction

endpackage

// File: rtl/os_edge_hist.sv
module os_edge_hist
   import os_rx_pkg::*;
#(
   parameter int OVS    = 3,
   parameter int WINDOW = 8
)(
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           grp_v_i,
   input  logic [OVS-1:0] grp_i,
   output phase_t         bnd_o
);
   localparam int CW = $clog2(WINDOW + 1);
   localparam int WW = $clog2(WINDOW);

   logic           last_q;
   logic [OVS-1:0] edge_w;
   logic [WW-1:0]  win_q;
   logic           close_w;
   logic [CW-1:0]  cnt_q [OVS];
   logic [CW-1:0]  tot_w [OVS];
   phase_t         best_w;
   logic           any_w;
   phase_t         bnd_q;

   // Position 0 compares against the previous group's last sample.
   assign edge_w[0] = last_q ^ grp_i[0];

   generate
      for (genvar p = 1; p < OVS; p++) begin : g_edge
         assign edge_w[p] = grp_i[p-1] ^ grp_i[p];
      end

      for (genvar p = 0; p < OVS; p++) begin : g_cnt
         assign tot_w[p] = cnt_q[p] + CW'(edge_w[p]);

         always_ff @(posedge clk_i) begin
            if (!rst_ni)      cnt_q[p] <= '0;
            else if (grp_v_i) cnt_q[p] <= close_w ? '0 : tot_w[p];
         end

         // R3: a running count never reaches a full window before clearing
         a_r3_hist_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cnt_q[p] < CW'(WINDOW));
      end
   endgenerate

   assign close_w = grp_v_i && (win_q == WW'(WINDOW - 1));

   // Largest count wins; strict compare keeps the lowest position on ties.
   always_comb begin
      logic [CW-1:0] best_c;
      best_w = '0;
      best_c = tot_w[0];
      any_w  = 1'b0;
      for (int p = 0; p < OVS; p++) begin
         if (tot_w[p] != '0) any_w = 1'b1;
         if (p > 0 && tot_w[p] > best_c) begin
            best_c = tot_w[p];
            best_w = phase_t'(p);
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         last_q <= 1'b0;
         win_q  <= '0;
         bnd_q  <= '0;
      end else if (grp_v_i) begin
         last_q <= grp_i[OVS-1];
         win_q  <= close_w ? '0 : win_q + 1'b1;
         if (close_w && any_w) bnd_q <= best_w;
      end
   end

   assign bnd_o = bnd_q;

   // R5: an edgeless window leaves the edge position untouched
   a_r5_keep_on_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (close_w && !any_w) |=> $stable(bnd_q));

   // R9: idle cycles do not move the window position
   a_r9_window_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !grp_v_i |=> $stable(win_q));

endmodule

// File: rtl/os_bit_pick.sv
module os_bit_pick
   import os_rx_pkg::*;
#(
   parameter int OVS = 3
)(
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           grp_v_i,
   input  logic [OVS-1:0] grp_i,
   input  phase_t         bnd_i,
   output logic [1:0]     bits_o,
   output logic [1:0]     cnt_o,
   output logic           vld_o
);
   localparam phase_t LAST = phase_t'(OVS - 1);

   phase_t     sel_w;
   phase_t     used_q;
   logic       add_w;
   logic       drop_w;
   logic [1:0] bits_d;
   logic [1:0] cnt_d;

   assign sel_w  = next_phase(bnd_i, OVS);
   assign add_w  = (used_q == '0)  && (sel_w == LAST);
   assign drop_w = (used_q == LAST) && (sel_w == '0);

   always_comb begin
      bits_d = '0;
      cnt_d  = '0;
      if (grp_v_i) begin
         if (add_w) begin
            bits_d = {grp_i[OVS-1], grp_i[0]};
            cnt_d  = 2'd2;
         end else if (!drop_w) begin
            bits_d[0] = grp_i[sel_w];
            cnt_d     = 2'd1;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         used_q <= phase_t'(1);
         bits_o <= '0;
         cnt_o  <= '0;
         vld_o  <= 1'b0;
      end else begin
         if (grp_v_i) used_q <= sel_w;
         bits_o <= bits_d;
         cnt_o  <= cnt_d;
         vld_o  <= (cnt_d != '0);
      end
   end

   // R4: the remembered selection stays inside the group
   a_r4_sel_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(used_q) < OVS);

   // R6: a forward wrap yields two bits in the next output cycle
   a_r6_two_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grp_v_i && used_q == '0 && sel_w == LAST) |=> (cnt_o == 2'd2 && vld_o));

   // R7: a backward wrap yields no bit in the next output cycle
   a_r7_no_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grp_v_i && used_q == LAST && sel_w == '0) |=> (cnt_o == 2'd0 && !vld_o));

   // R10: the valid flag follows the count
   a_r10_flag_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o == (cnt_o != 2'd0));

endmodule

// File: rtl/os_data_recover.sv
module os_data_recover
   import os_rx_pkg::*;
#(
   parameter int OVS    = 3,
   parameter int WINDOW = 8
)(
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           smp_vld_i,
   input  logic [OVS-1:0] smp_i,
   output logic [1:0]     bits_o,
   output logic [1:0]     bit_cnt_o,
   output logic           bits_vld_o
);
   generate
      if (OVS != 3) begin : g_bad_ovs
         $error("os_data_recover: OVS must be 3");
      end
      if (WINDOW < 2) begin : g_bad_window
         $error("os_data_recover: WINDOW must be at least 2");
      end
   endgenerate

   // One-group staging buffer between samplers and decision logic.
   logic           hold_v_q;
   logic [OVS-1:0] hold_q;
   phase_t         bnd_w;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hold_v_q <= 1'b0;
         hold_q   <= '0;
      end else begin
         hold_v_q <= smp_vld_i;
         if (smp_vld_i) hold_q <= smp_i;
      end
   end

   os_edge_hist #(.OVS(OVS), .WINDOW(WINDOW)) i_hist (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .grp_v_i (hold_v_q),
      .grp_i   (hold_q),
      .bnd_o   (bnd_w)
   );

   os_bit_pick #(.OVS(OVS)) i_pick (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .grp_v_i (hold_v_q),
      .grp_i   (hold_q),
      .bnd_i   (bnd_w),
      .bits_o  (bits_o),
      .cnt_o   (bit_cnt_o),
      .vld_o   (bits_vld_o)
   );

   // R9: an empty staging slot gives an empty output cycle
   a_r9_idle_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hold_v_q |=> (!bits_vld_o && bit_cnt_o == 2'd0));

   // R8: a valid input reaches the outputs two edges later
   a_r8_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      smp_vld_i |=> hold_v_q);

endmodule

// File: tb/test_os_data_recover.sv
`timescale 1ns/1ps
module test_os_data_recover;
   localparam int OVS = 3;
   localparam int WIN = 4;
   localparam int N   = 38;

   // Row: {valid, smp[2:0], expected count[1:0], expected bits[1:0]}
   localparam logic [7:0] TBL [N] = '{
      8'b1111_0101, 8'b1000_0100, 8'b1111_0101, 8'b1000_0100, // edge pos 0, sample 1 (R2 R4)
      8'b0000_0000,                                           // idle (R9)
      8'b1100_0100, 8'b1011_0101, 8'b1100_0100, 8'b1011_0101, // edges at pos 2
      8'b1110_0100, 8'b1001_0101, 8'b1110_0100,               // sample 0, edges at pos 1
      8'b0000_0000,                                           // idle inside a window (R9)
      8'b1001_0101,
      8'b1110_1010,                                           // 0 -> 2 wrap, two bits (R6)
      8'b1001_0100, 8'b1110_0101, 8'b1001_0100,
      8'b1100_0101, 8'b1011_0100, 8'b1100_0101, 8'b1011_0100, // edges at pos 2 again
      8'b1100_0000,                                           // 2 -> 0 wrap, no bit (R7)
      8'b1011_0101,
      8'b1000_0100, 8'b1000_0100, 8'b1000_0100, 8'b1000_0100, // quiet window follows
      8'b1000_0100, 8'b1000_0100,
      8'b1001_0101,                                           // still sample 0 (R5)
      8'b1000_0100, 8'b1000_0100, 8'b1000_0100,               // tie pos 0 vs 1
      8'b1010_0101,                                           // tie went to pos 0 (R3)
      8'b1100_0100, 8'b1011_0101, 8'b1100_0100                // leaves edge pos 2 before reset
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vld = 1'b0;
   logic [2:0] smp = '0;
   logic [1:0] bits;
   logic [1:0] cnt;
   logic       bvld;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   os_data_recover #(.OVS(OVS), .WINDOW(WIN)) i_os_data_recover (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .smp_vld_i  (vld),
      .smp_i      (smp),
      .bits_o     (bits),
      .bit_cnt_o  (cnt),
      .bits_vld_o (bvld)
   );

   task automatic check(input string req, input int row, input logic [4:0] exp);
      logic [4:0] act;
      act = {bvld, cnt, bits};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s row %0d: got vld/cnt/bits %b expected %b", req, row, act, exp);
      end
   endtask

   function automatic string tag_of(int i, logic [7:0] r);
      if (!r[7])          return "R9";
      if (r[3:2] == 2'd2) return "R6";
      if (r[3:2] == 2'd0) return "R7";
      if (i == 30)        return "R5";
      if (i == 34)        return "R3";
      if (i < 4)          return "R2";
      return "R4";
   endfunction

   initial begin
      #(20ns * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: outputs are clear while reset is held
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", -1, 5'b0_00_00);
      rst_n = 1'b1;

      // Table walk; output for row i shows two edges after it is driven (R8, R10)
      for (int i = 0; i < N + 2; i++) begin
         if (i >= 2) begin
            logic [7:0] r;
            r = TBL[i-2];
            check(tag_of(i - 2, r), i - 2, {(r[3:2] != 2'd0), r[3:0]});
         end
         if (i < N) begin
            vld = TBL[i][7];
            smp = TBL[i][6:4];
         end else begin
            vld = 1'b0;
            smp = '0;
         end
         @(posedge clk);
         @(negedge clk);
      end

      // R1: reset mid-stream clears outputs and returns to sample 1
      rst_n = 1'b0;
      vld   = 1'b1;
      smp   = 3'b111;
      @(posedge clk);
      @(negedge clk);
      check("R1", 100, 5'b0_00_00);
      rst_n = 1'b1;
      smp   = 3'b010;
      @(posedge clk);
      @(negedge clk);
      vld = 1'b0;
      smp = '0;
      @(posedge clk);
      @(negedge clk);
      check("R1", 101, 5'b1_01_01);

      // R8: nothing appears after only one edge
      vld = 1'b1;
      smp = 3'b010;
      @(posedge clk);
      @(negedge clk);
      vld = 1'b0;
      check("R8", 102, 5'b0_00_00);
      @(posedge clk);
      @(negedge clk);
      check("R8", 103, 5'b1_01_01);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule